// File: doc/BRIEF.md
# Indirect Debug Register Access Window

This block gives a management agent access to a wide array of internal debug registers through three 16-bit management registers. Two of these registers are staging latches that hold the low and high halves of a data word. The third is a command register. Writing the command register with its start bit set performs the transfer between the latches and the internal storage. A write access moves the latched word into the addressed entry. A read access copies the addressed entry back into the latches.

Each internal entry is 24 bits wide. An entry is selected by a three-level address (channel, node, data slot) that is packed into the command word. The window decodes only while the management page input equals the debug page value. On any other page the three addresses are left free for other logic.

The storage is a behavioural register file covering a parameterised subset of the address space. The management framing layer that drives the register port is outside this block. So is the page register itself.

Top module: `dbgw_top`

## Requirements
- R1: Accesses decode only while `page_sel` equals `WIN_PAGE` (default 0x52B5). On any other page, writes change neither the latches nor the storage, and `mgmt_rdata` reads 0.
- R2: A write to address 0x11 loads the low data latch. A read of address 0x11 returns that latch.
- R3: A write to address 0x12 loads the high data latch, keeping only bits 7:0. A read of 0x12 returns those 8 bits, with bits 15:8 reading as zero.
- R4: The command word at address 0x10 is decoded as follows. Bit 15 starts an access. Bit 13 selects a read (1) or a write (0). Bits 12:11 give the channel, bits 10:7 the node and bits 6:1 the data slot. Bits 14 and 0 are ignored.
- R5: A started write access stores {high latch[7:0], low latch} into the addressed entry at the command write edge. It leaves both latches unchanged.
- R6: A started read access copies the addressed entry into the latches at the command write edge. Reads of 0x11 and 0x12 from the next cycle on return entry[15:0] and {8'h00, entry[23:16]}.
- R7: A command write with bit 15 clear changes neither the storage nor the latches.
- R8: After reset, all storage entries and both latches hold zero.
- R9: An address whose node is at or above `NUM_NODE`, or whose data slot is at or above `NUM_DATA`, has no storage. A write to it is dropped without touching any other entry, and a read of it returns zero.
- R10: Reads of address 0x10, and of any address other than 0x11 and 0x12, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 16 | Currently selected management page |
| mgmt_wen | input | 1 | Register write strobe, one cycle per write |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Register write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr`, combinational |

## Verification
The assertions take three things for granted about the inputs. First, `page_sel` and `mgmt_addr` are stable values sampled at the clock edge. Second, each register write lasts exactly one cycle. Third, the read data for an address is wanted only in the same cycle as that address. The bench drives every input on the falling edge and holds the write strobe for a single rising edge. It samples `mgmt_rdata` shortly after presenting an address, so the assertions never see the strobe change half-way through a cycle. Changes of page take place only between accesses, never while a command is being written.

// File: rtl/dbgw_pkg.sv
`timescale 1ns/1ps
package dbgw_pkg;
  localparam logic [4:0] A_CMD = 5'h10;
  localparam logic [4:0] A_DLO = 5'h11;
  localparam logic [4:0] A_DHI = 5'h12;

  // command word field extraction
  function automatic logic cmd_start(input logic [15:0] w);
    return w[15];
  endfunction
  function automatic logic cmd_is_read(input logic [15:0] w);
    return w[13];
  endfunction
  function automatic logic [1:0] cmd_chan(input logic [15:0] w);
    return w[12:11];
  endfunction
  function automatic logic [3:0] cmd_node(input logic [15:0] w);
    return w[10:7];
  endfunction
  function automatic logic [5:0] cmd_slot(input logic [15:0] w);
    return w[6:1];
  endfunction
endpackage

// File: rtl/dbgw_decode.sv
`timescale 1ns/1ps
module dbgw_decode
  import dbgw_pkg::*;
#(
  parameter logic [15:0] WIN_PAGE = 16'h52B5
) (
  input  logic        wen,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  input  logic [15:0] page_sel,
  output logic        page_ok,
  output logic        wr_lo,
  output logic        wr_hi,
  output logic        fire_rd,
  output logic        fire_wr,
  output logic [1:0]  chan,
  output logic [3:0]  node,
  output logic [5:0]  slot
);
  logic cmd_wr;

  always_comb begin
    page_ok = (page_sel == WIN_PAGE);
    wr_lo   = page_ok && wen && (addr == A_DLO);
    wr_hi   = page_ok && wen && (addr == A_DHI);
    cmd_wr  = page_ok && wen && (addr == A_CMD) && cmd_start(wdata);
    fire_rd = cmd_wr && cmd_is_read(wdata);
    fire_wr = cmd_wr && !cmd_is_read(wdata);
    chan    = cmd_chan(wdata);
    node    = cmd_node(wdata);
    slot    = cmd_slot(wdata);
  end
endmodule

// File: rtl/dbgw_latch.sv
`timescale 1ns/1ps
module dbgw_latch #(
  parameter int ENTRY_W = 24,
  localparam int HI_W = ENTRY_W - 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [15:0]        wdata,
  input  logic               load_rd,
  input  logic [ENTRY_W-1:0] rd_entry,
  output logic [15:0]        lat_lo,
  output logic [HI_W-1:0]    lat_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_lo <= '0;
      lat_hi <= '0;
    end else if (load_rd) begin
      lat_lo <= rd_entry[15:0];
      lat_hi <= rd_entry[ENTRY_W-1:16];
    end else begin
      if (wr_lo) lat_lo <= wdata;
      if (wr_hi) lat_hi <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/dbgw_store.sv
`timescale 1ns/1ps
module dbgw_store #(
  parameter int ENTRY_W  = 24,
  parameter int NUM_CH   = 4,
  parameter int NUM_NODE = 16,
  parameter int NUM_DATA = 4,
  localparam int DEPTH   = NUM_CH * NUM_NODE * NUM_DATA,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         chan,
  input  logic [3:0]         node,
  input  logic [5:0]         slot,
  input  logic [ENTRY_W-1:0] wentry,
  output logic [ENTRY_W-1:0] rentry,
  output logic               commit
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic               in_range;
  logic [IDX_W-1:0]   idx;

  function automatic logic [IDX_W-1:0] flat_index(input logic [1:0] c,
                                                  input logic [3:0] n,
                                                  input logic [5:0] s);
    int v;
    v = (int'(c) * NUM_NODE + int'(n)) * NUM_DATA + int'(s);
    return IDX_W'(v);
  endfunction

  always_comb begin
    in_range = (int'(chan) < NUM_CH) && (int'(node) < NUM_NODE) &&
               (int'(slot) < NUM_DATA);
    idx      = flat_index(chan, node, slot);
    commit   = we && in_range;
    rentry   = in_range ? mem[idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[idx] <= wentry;
    end
  end
endmodule

// File: rtl/dbgw_top.sv
`timescale 1ns/1ps
module dbgw_top
  import dbgw_pkg::*;
#(
  parameter logic [15:0] WIN_PAGE = 16'h52B5,
  parameter int ENTRY_W  = 24,
  parameter int NUM_CH   = 4,
  parameter int NUM_NODE = 16,
  parameter int NUM_DATA = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] page_sel,
  input  logic        mgmt_wen,
  input  logic [4:0]  mgmt_addr,
  input  logic [15:0] mgmt_wdata,
  output logic [15:0] mgmt_rdata
);
  localparam int HI_W = ENTRY_W - 16;

  logic               page_ok, wr_lo, wr_hi, fire_rd, fire_wr, st_we;
  logic [1:0]         chan;
  logic [3:0]         node;
  logic [5:0]         slot;
  logic [15:0]        lat_lo;
  logic [HI_W-1:0]    lat_hi;
  logic [ENTRY_W-1:0] rentry;

  dbgw_decode #(.WIN_PAGE(WIN_PAGE)) u_dec (
    .wen(mgmt_wen), .addr(mgmt_addr), .wdata(mgmt_wdata), .page_sel(page_sel),
    .page_ok(page_ok), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .fire_rd(fire_rd), .fire_wr(fire_wr),
    .chan(chan), .node(node), .slot(slot)
  );

  dbgw_store #(.ENTRY_W(ENTRY_W), .NUM_CH(NUM_CH), .NUM_NODE(NUM_NODE),
               .NUM_DATA(NUM_DATA)) u_store (
    .clk(clk), .rst_n(rst_n), .we(fire_wr),
    .chan(chan), .node(node), .slot(slot),
    .wentry({lat_hi, lat_lo}), .rentry(rentry), .commit(st_we)
  );

  dbgw_latch #(.ENTRY_W(ENTRY_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(mgmt_wdata), .load_rd(fire_rd), .rd_entry(rentry),
    .lat_lo(lat_lo), .lat_hi(lat_hi)
  );

  always_comb begin
    mgmt_rdata = '0;
    if (page_ok) begin
      case (mgmt_addr)
        A_DLO:   mgmt_rdata = lat_lo;
        A_DHI:   mgmt_rdata = {{(16-HI_W){1'b0}}, lat_hi};
        default: mgmt_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbgw_chk.sv
`timescale 1ns/1ps
module dbgw_chk #(
  parameter logic [15:0] WIN_PAGE = 16'h52B5,
  parameter int HI_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      page_sel,
  input logic             mgmt_wen,
  input logic [4:0]       mgmt_addr,
  input logic [15:0]      mgmt_wdata,
  input logic [15:0]      mgmt_rdata,
  input logic             fire_rd,
  input logic             fire_wr,
  input logic             st_we,
  input logic [15:0]      lat_lo,
  input logic [HI_W-1:0]  lat_hi,
  input logic [HI_W+15:0] rentry
);
  logic on_page;
  assign on_page = (page_sel == WIN_PAGE);

  // R1
  off_page_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_page && mgmt_wen) |=> ($stable(lat_lo) && $stable(lat_hi)));

  // R1
  off_page_nocommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_page |-> !st_we);

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_page && mgmt_wen && mgmt_addr == 5'h11) |=> lat_lo == $past(mgmt_wdata));

  // R3
  hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_page && mgmt_addr == 5'h12) |-> mgmt_rdata[15:HI_W] == '0);

  // R5
  wr_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_wr |=> ($stable(lat_lo) && $stable(lat_hi)));

  // R6
  rd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rd |=> (lat_lo == $past(rentry[15:0]) && lat_hi == $past(rentry[HI_W+15:16])));

  // R7
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wen && mgmt_addr == 5'h10 && !mgmt_wdata[15]) |-> (!st_we && !fire_rd));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_rd && fire_wr));
endmodule

bind dbgw_top dbgw_chk #(.WIN_PAGE(WIN_PAGE), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mgmt_wen(mgmt_wen),
  .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
  .fire_rd(fire_rd), .fire_wr(fire_wr), .st_we(st_we),
  .lat_lo(lat_lo), .lat_hi(lat_hi), .rentry(rentry)
);

// File: tb/dbgw_top_test.sv
`timescale 1ns/1ps
module dbgw_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] page_sel = 16'h52B5;
  logic        mgmt_wen = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  int checks = 0;
  int errors = 0;

  localparam logic [15:0] DBG_PAGE = 16'h52B5;

  dbgw_top uut (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mgmt_wen(mgmt_wen),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata)
  );

  always #2.5 clk = ~clk;

  // command word built by arithmetic, independent of the RTL field helpers
  function automatic logic [15:0] mk_cmd(input bit go, input bit rd,
                                         input int ch, input int nd, input int sl);
    int v;
    v = (go ? 32768 : 0) + (rd ? 8192 : 0) + ch * 2048 + nd * 128 + sl * 2;
    return 16'(v);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a; mgmt_wdata = d; mgmt_wen = 1'b1;
    @(negedge clk);
    mgmt_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    mgmt_addr = a;
    #1 d = mgmt_rdata;
  endtask

  task automatic put_entry(input int ch, input int nd, input int sl, input logic [23:0] v);
    wr(5'h11, v[15:0]);
    wr(5'h12, {8'h00, v[23:16]});
    wr(5'h10, mk_cmd(1, 0, ch, nd, sl));
  endtask

  task automatic get_entry(input int ch, input int nd, input int sl, output logic [23:0] v);
    logic [15:0] lo, hi;
    wr(5'h10, mk_cmd(1, 1, ch, nd, sl));
    rd(5'h11, lo);
    rd(5'h12, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic t_reset();
    logic [15:0] d;
    logic [23:0] e;
    rd(5'h11, d); chk("R8 lo latch after reset", d, 16'h0);
    rd(5'h12, d); chk("R8 hi latch after reset", d, 16'h0);
    get_entry(3, 15, 3, e); chk("R8 entry after reset", e[15:0], 16'h0);
    chk("R8 entry hi after reset", {8'h0, e[23:16]}, 16'h0);
  endtask

  task automatic t_latches();
    logic [15:0] d;
    wr(5'h11, 16'hBEEF);
    rd(5'h11, d); chk("R2 lo latch readback", d, 16'hBEEF);
    wr(5'h12, 16'hFFA5);
    rd(5'h12, d); chk("R3 hi latch keeps 8 bits", d, 16'h00A5);
  endtask

  task automatic t_write_read();
    logic [15:0] d;
    logic [23:0] e;
    put_entry(2, 15, 3, 24'hA5BEEF);
    rd(5'h11, d); chk("R5 lo latch unchanged by write access", d, 16'hBEEF);
    rd(5'h12, d); chk("R5 hi latch unchanged by write access", d, 16'h00A5);
    wr(5'h11, 16'h0000); wr(5'h12, 16'h0000);
    wr(5'h10, mk_cmd(1, 1, 2, 15, 3));
    // read of data-low on the very next cycle after the command
    rd(5'h11, d); chk("R6 lo after read access", d, 16'hBEEF);
    rd(5'h12, d); chk("R6 hi after read access", d, 16'h00A5);
  endtask

  task automatic t_fields();
    logic [23:0] e;
    put_entry(0, 0, 0, 24'h000001);
    put_entry(1, 0, 0, 24'h000010);
    put_entry(0, 1, 0, 24'h000100);
    put_entry(0, 0, 1, 24'h001000);
    put_entry(3, 8, 2, 24'h7F1234);
    get_entry(0, 0, 0, e); chk("R4 base entry", e[15:0], 16'h0001);
    get_entry(1, 0, 0, e); chk("R4 channel field", e[15:0], 16'h0010);
    get_entry(0, 1, 0, e); chk("R4 node field", e[15:0], 16'h0100);
    get_entry(0, 0, 1, e); chk("R4 slot field", e[15:0], 16'h1000);
    // bits 14 and 0 set: must address the same entry
    wr(5'h10, mk_cmd(1, 1, 3, 8, 2) | 16'h4001);
    rd(5'h11, e[15:0]); chk("R4 reserved bits ignored lo", e[15:0], 16'h1234);
    rd(5'h12, e[15:0]); chk("R4 reserved bits ignored hi", e[15:0], 16'h007F);
  endtask

  task automatic t_nostart();
    logic [15:0] d;
    logic [23:0] e;
    put_entry(1, 5, 1, 24'h112233);
    wr(5'h11, 16'h5555); wr(5'h12, 16'h0066);
    wr(5'h10, mk_cmd(0, 0, 1, 5, 1));
    wr(5'h10, mk_cmd(0, 1, 1, 5, 1));
    rd(5'h11, d); chk("R7 latch lo kept without start", d, 16'h5555);
    rd(5'h12, d); chk("R7 latch hi kept without start", d, 16'h0066);
    get_entry(1, 5, 1, e); chk("R7 storage kept without start", e[15:0], 16'h2233);
  endtask

  task automatic t_offpage();
    logic [15:0] d;
    logic [23:0] e;
    wr(5'h11, 16'h4321);
    page_sel = 16'h0000;
    rd(5'h11, d); chk("R1 off page read zero", d, 16'h0000);
    wr(5'h11, 16'h7777);
    wr(5'h12, 16'h0011);
    wr(5'h10, mk_cmd(1, 0, 0, 2, 2));
    page_sel = DBG_PAGE;
    rd(5'h11, d); chk("R1 off page write ignored", d, 16'h4321);
    get_entry(0, 2, 2, e); chk("R1 off page command ignored", e[15:0], 16'h0000);
  endtask

  task automatic t_range();
    logic [23:0] e;
    put_entry(2, 4, 1, 24'h00C0DE);
    put_entry(2, 4, 5, 24'hABCDEF);
    get_entry(2, 4, 5, e); chk("R9 unmapped slot reads zero", e[15:0], 16'h0000);
    get_entry(2, 4, 1, e); chk("R9 no alias into mapped entry", e[15:0], 16'hC0DE);
  endtask

  task automatic t_other_addr();
    logic [15:0] d;
    wr(5'h11, 16'h9999);
    rd(5'h10, d); chk("R10 command reads zero", d, 16'h0000);
    rd(5'h05, d); chk("R10 unused address reads zero", d, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latches();
    t_write_read();
    t_fields();
    t_nostart();
    t_offpage();
    t_range();
    t_other_addr();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule